// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This block rearranges the elements of one vector register under a per-element mask. A mask holds one bit for each element. In compress mode, the elements whose mask bit is set are gathered in ascending order into the lowest destination slots. Every slot above them is cleared. In expand mode the operation runs the other way: consecutive source elements are placed into the slots whose mask bit is set, and every other slot keeps the value the destination register already held.

A caller pulses `start_i` for one cycle with the mode, the active vector length, the mask and the source vector. The unit latches these inputs and walks the active elements, one per clock. It then pulses `done_o`. The rearranged vector stays on `dst_o` until the next operation starts. The number of mask bits set within the active length stays on `len_o` for the same period. The destination is state held inside the unit, so an expand works on top of the previous result.

Top module: `vmask_permute`

## Requirements
- R1: In compress mode (`mode_i` = 0), the k-th set mask bit counted from element 0 selects the source element that appears in destination element k. Element i occupies bits [i*ELEM_W +: ELEM_W].
- R2: In compress mode, every destination element at an index equal to or above the result length reads zero once the operation finishes.
- R3: When `done_o` is high, `len_o` equals the number of set mask bits with an index below the active length. This holds in both modes.
- R4: In expand mode (`mode_i` = 1), the k-th source element, counted from element 0, is written to the position of the k-th set mask bit.
- R5: In expand mode, destination elements whose mask bit is clear keep the value they held before the start. The same applies to elements at or above the active length.
- R6: Mask bits at an index equal to or greater than the active length have no effect on `dst_o` or `len_o`.
- R7: `done_o` is a one-cycle pulse. It rises max(VL,1) clock edges after the edge that accepted the start. The active length VL is `vl_i` clamped to NUM_ELEM.
- R8: With no mask bit set below the active length, compress returns length 0 and an all-zero destination, and expand returns length 0 and leaves the destination unchanged.
- R9: A start strobe that arrives while an operation is in progress is ignored. The running operation finishes with its own inputs.
- R10: After reset, `dst_o` is all zero, `len_o` is 0 and `done_o` is low. Both outputs hold their values while the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only while idle |
| mode_i | input | 1 | 0 = compress, 1 = expand |
| vl_i | input | LEN_W | Active vector length (clamped to NUM_ELEM) |
| mask_i | input | NUM_ELEM | One mask bit per element |
| src_i | input | NUM_ELEM*ELEM_W | Source vector, element i at bits [i*ELEM_W +: ELEM_W] |
| dst_o | output | NUM_ELEM*ELEM_W | Destination vector register |
| len_o | output | LEN_W | Packed length (mask population count below VL) |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Sparse, irregular masks in both modes distinguish correct ordering from element reversal or off-by-one slot indexing. Running expand directly after compress shows whether clear positions keep the earlier result rather than zero or source data. Full masks combined with a short active length reveal whether mask bits above the active length leak into the result. Empty masks, a zero length and an oversized length probe the count, the tail clearing and the latency edges, and a second strobe during a long operation shows whether it corrupts the operation already running.

// File: rtl/vmp_pkg.sv
package vmp_pkg;
    typedef enum logic {
        VMP_COMPRESS = 1'b0,
        VMP_EXPAND   = 1'b1
    } vmp_mode_e;
endpackage

// File: rtl/vmp_decode.sv
// Index to one-hot decoder for the element being walked.
module vmp_decode #(
    parameter int NUM = 8,
    parameter int IW  = 4
) (
    input  logic [IW-1:0]  idx_i,
    output logic [NUM-1:0] hot_o
);
    always_comb begin
        for (int i = 0; i < NUM; i++) begin
            hot_o[i] = (idx_i == IW'(i));
        end
    end
endmodule

// File: rtl/vmp_pick.sv
// Selects one element of a packed vector.
module vmp_pick #(
    parameter int NUM = 8,
    parameter int W   = 16,
    parameter int IW  = 4
) (
    input  logic [NUM*W-1:0] vec_i,
    input  logic [IW-1:0]    sel_i,
    output logic [W-1:0]     elem_o
);
    always_comb begin
        elem_o = '0;
        for (int i = 0; i < NUM; i++) begin
            if (sel_i == IW'(i)) begin
                elem_o = vec_i[i*W +: W];
            end
        end
    end
endmodule

// File: rtl/vmp_place.sv
// Replaces one element of a packed vector when enabled.
module vmp_place #(
    parameter int NUM = 8,
    parameter int W   = 16,
    parameter int IW  = 4
) (
    input  logic [NUM*W-1:0] vec_i,
    input  logic             we_i,
    input  logic [IW-1:0]    pos_i,
    input  logic [W-1:0]     data_i,
    output logic [NUM*W-1:0] vec_o
);
    for (genvar g = 0; g < NUM; g++) begin : g_slot
        assign vec_o[g*W +: W] = (we_i && (pos_i == IW'(g))) ? data_i : vec_i[g*W +: W];
    end
endmodule

// File: rtl/vmask_permute.sv
module vmask_permute
    import vmp_pkg::*;
#(
    parameter  int NUM_ELEM = 8,
    parameter  int ELEM_W   = 16,
    localparam int LEN_W    = $clog2(NUM_ELEM + 1),
    localparam int VEC_W    = NUM_ELEM * ELEM_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic [LEN_W-1:0] vl_i,
    input  logic [NUM_ELEM-1:0] mask_i,
    input  logic [VEC_W-1:0] src_i,
    output logic [VEC_W-1:0] dst_o,
    output logic [LEN_W-1:0] len_o,
    output logic             done_o
);
    typedef struct packed {
        logic                busy;
        logic                done;
        vmp_mode_e           mode;
        logic [LEN_W-1:0]    vl;
        logic [NUM_ELEM-1:0] mask;
        logic [VEC_W-1:0]    src;
        logic [LEN_W-1:0]    idx;
        logic [LEN_W-1:0]    ptr;
        logic [VEC_W-1:0]    dst;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_ELEM-1:0] idx_hot;
    logic [LEN_W-1:0]    rd_sel, wr_pos;
    logic [ELEM_W-1:0]   rd_elem;
    logic                hit;
    logic [VEC_W-1:0]    dst_wr;

    vmp_decode #(.NUM(NUM_ELEM), .IW(LEN_W)) u_dec (
        .idx_i (st_q.idx),
        .hot_o (idx_hot)
    );

    // Compress reads at the walk index and writes at the pack pointer;
    // expand does the reverse.
    assign rd_sel = (st_q.mode == VMP_COMPRESS) ? st_q.idx : st_q.ptr;
    assign wr_pos = (st_q.mode == VMP_COMPRESS) ? st_q.ptr : st_q.idx;
    assign hit    = st_q.busy && (st_q.idx < st_q.vl) && (|(st_q.mask & idx_hot));

    vmp_pick #(.NUM(NUM_ELEM), .W(ELEM_W), .IW(LEN_W)) u_pick (
        .vec_i  (st_q.src),
        .sel_i  (rd_sel),
        .elem_o (rd_elem)
    );

    vmp_place #(.NUM(NUM_ELEM), .W(ELEM_W), .IW(LEN_W)) u_place (
        .vec_i  (st_q.dst),
        .we_i   (hit),
        .pos_i  (wr_pos),
        .data_i (rd_elem),
        .vec_o  (dst_wr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            st_d.dst = dst_wr;
            if (hit) begin
                st_d.ptr = st_q.ptr + LEN_W'(1);
            end
            st_d.idx = st_q.idx + LEN_W'(1);
            if ((st_q.idx + LEN_W'(1)) >= st_q.vl) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.mode = vmp_mode_e'(mode_i);
            st_d.vl   = (vl_i > LEN_W'(NUM_ELEM)) ? LEN_W'(NUM_ELEM) : vl_i;
            st_d.mask = mask_i;
            st_d.src  = src_i;
            st_d.idx  = '0;
            st_d.ptr  = '0;
            if (vmp_mode_e'(mode_i) == VMP_COMPRESS) begin
                st_d.dst = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dst_o  = st_q.dst;
    assign len_o  = st_q.ptr;
    assign done_o = st_q.done;

    logic             busy_w;
    logic             mode_w;
    logic [LEN_W-1:0] vl_w;
    assign busy_w = st_q.busy;
    assign mode_w = st_q.mode;
    assign vl_w   = st_q.vl;
endmodule

// File: rtl/vmp_checks.sv
module vmp_checks #(
    parameter int N  = 8,
    parameter int W  = 16,
    parameter int LW = 4
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          start_i,
    input logic          busy_i,
    input logic          mode_i,
    input logic [LW-1:0] vl_i,
    input logic [LW-1:0] len_i,
    input logic [N*W-1:0] dst_i,
    input logic          done_i
);
    logic tail_ok;
    always_comb begin
        tail_ok = 1'b1;
        for (int i = 0; i < N; i++) begin
            if ((LW'(i) >= len_i) && (dst_i[i*W +: W] != '0)) begin
                tail_ok = 1'b0;
            end
        end
    end

    // R7: completion is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i);

    // R7: completion coincides with the unit going idle
    a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> !busy_i);

    // R3: packed length never exceeds the active length
    a_r3_len_within_vl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> (len_i <= vl_i));

    // R2: compress leaves zeros above the packed length
    a_r2_tail_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !mode_i) |-> tail_ok);

    // R10: idle without a start keeps outputs steady
    a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_i && !start_i) |=> ($stable(len_i) && $stable(dst_i)));
endmodule

bind vmask_permute vmp_checks #(.N(NUM_ELEM), .W(ELEM_W), .LW(LEN_W)) u_checks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_i  (busy_w),
    .mode_i  (mode_w),
    .vl_i    (vl_w),
    .len_i   (len_o),
    .dst_i   (dst_o),
    .done_i  (done_o)
);

// File: tb/vmask_permute_test.sv
`timescale 1ns/1ps
module vmask_permute_test;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int LW = $clog2(N + 1);
    localparam int NW = N * W;

    typedef struct {
        logic [NW-1:0] dst;
        logic [LW-1:0] len;
        int            done_edge;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [LW-1:0] vl = '0;
    logic [N-1:0]  mask = '0;
    logic [NW-1:0] src = '0;
    logic [NW-1:0] dst;
    logic [LW-1:0] len;
    logic          done;

    exp_t          sbq[$];
    int            checks = 0;
    int            fails = 0;
    int            cyc = 0;
    logic          prev_done = 1'b0;
    logic [NW-1:0] shadow = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vmask_permute #(.NUM_ELEM(N), .ELEM_W(W)) uut (
        .clk_i (clk), .rst_ni (rst_n), .start_i (start), .mode_i (mode),
        .vl_i (vl), .mask_i (mask), .src_i (src),
        .dst_o (dst), .len_o (len), .done_o (done)
    );

    task automatic chk(input string tag, input string what, input logic [NW-1:0] act, input logic [NW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [NW-1:0] mk_src(input int seed);
        logic [NW-1:0] s;
        for (int i = 0; i < N; i++) s[i*W +: W] = W'(seed * 257 + i * 17 + 1);
        return s;
    endfunction

    // Model, push expectation, drive; optionally inject a second start while busy.
    task automatic run_op(input logic md, input logic [LW-1:0] v, input logic [N-1:0] m,
                          input logic [NW-1:0] s, input string tag, input bit inject);
        exp_t e;
        int n, k;
        logic [NW-1:0] o;
        n = (int'(v) > N) ? N : int'(v);
        k = 0;
        o = md ? shadow : '0;
        for (int i = 0; i < n; i++) begin
            if (m[i]) begin
                if (!md) o[k*W +: W] = s[i*W +: W];
                else     o[i*W +: W] = s[k*W +: W];
                k++;
            end
        end
        shadow      = o;
        e.dst       = o;
        e.len       = LW'(k);
        e.done_edge = cyc + 1 + ((n == 0) ? 1 : n);
        e.tag       = tag;
        sbq.push_back(e);
        start = 1'b1; mode = md; vl = v; mask = m; src = s;
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            @(negedge clk);
            start = 1'b1; mode = ~md; vl = LW'(2); mask = '1; src = mk_src(99);
            @(negedge clk);
            start = 1'b0;
        end
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (prev_done) begin
                    checks++; fails++;
                    $display("FAIL R7 done held two cycles actual=1 expected=0");
                end
                if (sbq.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R7 unexpected done actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(e.tag, "dst", dst, e.dst);
                    chk(e.tag, "len (R3)", NW'(len), NW'(e.len));
                    chk(e.tag, "done edge (R7)", NW'(cyc), NW'(e.done_edge));
                end
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run did not finish actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10", "dst after reset", dst, '0);
        chk("R10", "len after reset", NW'(len), '0);
        chk("R10", "done after reset", NW'(done), '0);

        run_op(1'b0, LW'(8), 8'b1010_0110, mk_src(1), "R1 R2 compress sparse", 1'b0);
        run_op(1'b1, LW'(8), 8'b0101_1001, mk_src(2), "R4 R5 expand over previous", 1'b0);
        run_op(1'b0, LW'(8), 8'b1111_1111, mk_src(3), "R1 compress full", 1'b0);
        run_op(1'b0, LW'(5), 8'b1111_1111, mk_src(4), "R6 compress short VL", 1'b0);
        run_op(1'b1, LW'(6), 8'b1111_0000, mk_src(5), "R6 R5 expand short VL", 1'b0);
        run_op(1'b1, LW'(8), 8'b1000_0010, mk_src(6), "R4 expand sparse", 1'b0);
        run_op(1'b0, LW'(8), 8'b0000_0000, mk_src(7), "R8 compress empty mask", 1'b0);
        run_op(1'b1, LW'(8), 8'b1100_0011, mk_src(8), "R4 expand after clear", 1'b0);
        run_op(1'b1, LW'(8), 8'b0000_0000, mk_src(9), "R8 expand empty mask", 1'b0);
        run_op(1'b1, LW'(3), 8'b1111_1000, mk_src(10), "R6 R8 expand mask above VL", 1'b0);
        run_op(1'b0, LW'(0), 8'b1111_1111, mk_src(11), "R7 compress zero VL", 1'b0);
        run_op(1'b1, LW'(12), 8'b1000_0001, mk_src(12), "R7 expand clamped VL", 1'b0);
        run_op(1'b0, LW'(8), 8'b0110_1101, mk_src(13), "R9 start while busy", 1'b0 | 1'b1);
        run_op(1'b0, LW'(1), 8'b0000_0001, mk_src(14), "R7 compress single", 1'b0);

        // R10: outputs hold while idle
        repeat (4) @(negedge clk);
        chk("R10", "dst idle hold", dst, shadow);
        chk("R10", "done idle", NW'(done), '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule